// File: doc/BRIEF.md
# Receive Interface Gain Slicer

This block sits at the end of a receive datapath. It takes a stream of 22-bit signed I/Q samples and applies an interface gain that is a power of two, in 6 dB steps from 0 dB to 18 dB (a left shift of 0 to 3 bits). It then formats each sample pair for a parallel data port. The gain code can come from the host through an input register field. It can also be picked internally from a dB-scaled power estimate of the signal entering the block: each 6 dB of power above a signal that just fills 16 bits removes one step of gain, so loud signals do not clip. Wideband operation always forces the gain to 0 dB.

Two output formats are available. The rounded format shifts each sample and rounds it to 16 bits, half away from zero. It then clips the result to ±32767 and sign-extends it into a 32-bit word. The full format skips gain and rounding. It places the raw 22-bit sample in the top of a 32-bit word, followed by a one-bit change flag and a 9-bit auxiliary field. A select input picks that field: zeros, the applied gain code, or a gain index supplied from outside. The gain code applied to the most recent output is always visible, so downstream logic can rescale the received power.

Top module: `rx_iface_slicer`

## Requirements
- R1: In narrowband operation the applied gain code g (0..3) scales the sample by 2^g before rounding.
- R2: When `narrowband` is low, the applied gain code is 0 whatever the control source and setting.
- R3: With `ext_ctrl` high in narrowband operation, the code applied to a valid sample equals `ext_code`.
- R4: With internal control, headroom = 200 - `power` (0 when `power` >= 200, 0.5 dB per count). The code is 1, 2 or 3 when the headroom reaches 12, 24 or 36 counts, and 0 below 12.
- R5: Internal selection lowers the code at once when headroom falls below a step. It raises the code only when the headroom exceeds that step's threshold by at least one count (thresholds 13/25/37 going up).
- R6: The code changes only on a sample with `in_valid` high, and that sample's I and Q use the same code. `cur_gain` shows the code of the latest output sample and holds while no sample arrives.
- R7: With `fmt_full` low, each output word holds round(x·2^g/64), rounded half away from zero, clipped to [-32767, 32767] and sign-extended over bits [31:0].
- R8: With `fmt_full` high, bits [31:10] of each word are the unshifted, unrounded 22-bit input sample.
- R9: In full format, bit [9] is 1 when the sample's code differs from the previous sample's code, or when `agc_changed` is high with that sample. Otherwise it is 0.
- R10: In full format, bits [8:0] follow `aux_sel`: 0 gives zeros, 1 gives the applied code zero-extended, 2 gives `ext_index`, and 3 gives zeros.
- R11: `out_valid` follows `in_valid` one clock later. Output words hold while no sample arrives. After reset, `out_valid`, both words and `cur_gain` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 22 | In-phase sample, signed |
| in_q | input | 22 | Quadrature sample, signed |
| power | input | 8 | Unsigned power estimate, 0.5 dB per count, 200 = full scale |
| narrowband | input | 1 | 1 = narrowband (gain allowed), 0 = wideband (gain 0) |
| ext_ctrl | input | 1 | 1 = host sets the gain, 0 = internal selection |
| ext_code | input | 2 | Host gain code |
| fmt_full | input | 1 | 1 = full 22-bit packed format, 0 = 16-bit rounded |
| aux_sel | input | 2 | Auxiliary field select |
| ext_index | input | 9 | External gain index for the auxiliary field |
| agc_changed | input | 1 | Front-end gain changed with this sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 32 | In-phase output word |
| out_q | output | 32 | Quadrature output word |
| cur_gain | output | 2 | Gain code of the latest output sample |

## Verification
The only internal state is the held gain code. A wrong value shows on `cur_gain` on the clock after the sample that wrote it. The next sample then shows it as well: its rounded value is scaled by the wrong power of two, or its change flag is wrong in full format. A fault in the hysteresis shows only when the power estimate sits exactly one count from a threshold. The bench therefore walks the power across each edge in both directions. It also compares every output against a behavioural model on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int SMP_W    = 22;
    localparam int OUT_W    = 16;
    localparam int AUX_W    = 9;
    localparam int GAIN_W   = 2;
    localparam int PWR_W    = 8;
    localparam int PWR_FS   = 200;
    localparam int STEP_CNT = 12;
    localparam int HYST_CNT = 1;
    localparam int LANES    = 2;
    localparam int WORD_W   = SMP_W + 1 + AUX_W;

    typedef enum logic [1:0] {
        AUX_ZERO  = 2'd0,
        AUX_GAIN  = 2'd1,
        AUX_INDEX = 2'd2,
        AUX_RSVD  = 2'd3
    } aux_sel_e;

    typedef enum logic {
        FMT_ROUND16 = 1'b0,
        FMT_FULL    = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [GAIN_W-1:0] code;
        logic              changed;
    } gain_dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] i;
        logic [WORD_W-1:0] q;
    } iq_word_t;

    function automatic logic [AUX_W-1:0] aux_pick(aux_sel_e sel,
                                                 logic [GAIN_W-1:0] code,
                                                 logic [AUX_W-1:0] idx);
        logic [AUX_W-1:0] r;
        case (sel)
            AUX_GAIN:  r = AUX_W'(code);
            AUX_INDEX: r = idx;
            default:   r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rxs_gain_sel.sv
module rxs_gain_sel
    import rxs_pkg::*;
#(
    parameter int FS   = PWR_FS,
    parameter int STEP = STEP_CNT,
    parameter int HYST = HYST_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              narrowband,
    input  logic              ext_ctrl,
    input  logic [GAIN_W-1:0] ext_code,
    input  logic [PWR_W-1:0]  power,
    output gain_dec_t         dec,
    output logic [GAIN_W-1:0] held
);
    localparam int              MAX_CODE = (1 << GAIN_W) - 1;
    localparam logic [PWR_W-1:0] FS_L    = PWR_W'(FS);

    logic [PWR_W-1:0]  headroom;
    logic [GAIN_W-1:0] code_down;
    logic [GAIN_W-1:0] code_up;
    logic [GAIN_W-1:0] pick;

    always_comb begin
        headroom = (power >= FS_L) ? '0 : FS_L - power;
    end

    always_comb begin
        code_down = '0;
        code_up   = '0;
        for (int k = 1; k <= MAX_CODE; k++) begin
            if (int'(headroom) >= k * STEP)        code_down = GAIN_W'(k);
            if (int'(headroom) >= k * STEP + HYST) code_up   = GAIN_W'(k);
        end
    end

    always_comb begin
        if (!narrowband)           pick = '0;
        else if (ext_ctrl)         pick = ext_code;
        else if (code_down < held) pick = code_down;
        else if (code_up > held)   pick = code_up;
        else                       pick = held;
        dec.code    = pick;
        dec.changed = (pick != held);
    end

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (in_valid) held <= pick;
    end
endmodule

// File: rtl/rxs_lane_round.sv
module rxs_lane_round
    import rxs_pkg::*;
(
    input  logic signed [SMP_W-1:0] smp,
    input  logic [GAIN_W-1:0]       code,
    output logic [WORD_W-1:0]       word
);
    localparam int SH_W  = SMP_W + (1 << GAIN_W) - 1;
    localparam int MAG_W = SH_W + 1;
    localparam int DROP  = SMP_W - OUT_W;
    localparam int Q_W   = MAG_W - DROP;
    localparam logic [Q_W-1:0]   POS_MAX = Q_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [MAG_W-1:0] HALF    = MAG_W'(1 << (DROP - 1));

    logic signed [SH_W-1:0]  shifted;
    logic signed [MAG_W-1:0] wide;
    logic                    neg;
    logic [MAG_W-1:0]        mag;
    logic [MAG_W-1:0]        rnd;
    logic [Q_W-1:0]          quo;
    logic [OUT_W-1:0]        lim;
    logic [OUT_W-1:0]        res;

    always_comb begin
        shifted = SH_W'(smp) <<< code;
        wide    = MAG_W'(shifted);
        neg     = shifted[SH_W-1];
        mag     = neg ? MAG_W'(-wide) : MAG_W'(wide);
        rnd     = mag + HALF;
        quo     = rnd[MAG_W-1:DROP];
        lim     = (quo > POS_MAX) ? POS_MAX[OUT_W-1:0] : quo[OUT_W-1:0];
        res     = neg ? (~lim + 1'b1) : lim;
        word    = {{(WORD_W - OUT_W){res[OUT_W-1]}}, res};
    end
endmodule

// File: rtl/rxs_lane_fmt.sv
module rxs_lane_fmt
    import rxs_pkg::*;
(
    input  logic [SMP_W-1:0]  smp,
    input  logic [GAIN_W-1:0] code,
    input  fmt_e              fmt,
    input  logic              flag,
    input  logic [AUX_W-1:0]  aux,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] rounded;

    rxs_lane_round u_round (
        .smp  (smp),
        .code (code),
        .word (rounded)
    );

    always_comb begin
        word = (fmt == FMT_FULL) ? {smp, flag, aux} : rounded;
    end
endmodule

// File: rtl/rx_iface_slicer.sv
module rx_iface_slicer
    import rxs_pkg::*;
#(
    parameter int FS   = PWR_FS,
    parameter int STEP = STEP_CNT,
    parameter int HYST = HYST_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_i,
    input  logic [SMP_W-1:0]  in_q,
    input  logic [PWR_W-1:0]  power,
    input  logic              narrowband,
    input  logic              ext_ctrl,
    input  logic [GAIN_W-1:0] ext_code,
    input  logic              fmt_full,
    input  logic [1:0]        aux_sel,
    input  logic [AUX_W-1:0]  ext_index,
    input  logic              agc_changed,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_i,
    output logic [WORD_W-1:0] out_q,
    output logic [GAIN_W-1:0] cur_gain
);
    gain_dec_t        dec;
    logic             flag;
    logic [AUX_W-1:0] aux;
    logic [SMP_W-1:0] lane_smp  [LANES];
    logic [WORD_W-1:0] lane_word [LANES];
    iq_word_t         nxt;
    iq_word_t         held_q;

    rxs_gain_sel #(
        .FS   (FS),
        .STEP (STEP),
        .HYST (HYST)
    ) u_gain (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .narrowband (narrowband),
        .ext_ctrl   (ext_ctrl),
        .ext_code   (ext_code),
        .power      (power),
        .dec        (dec),
        .held       (cur_gain)
    );

    always_comb begin
        flag        = dec.changed | agc_changed;
        aux         = aux_pick(aux_sel_e'(aux_sel), dec.code, ext_index);
        lane_smp[0] = in_i;
        lane_smp[1] = in_q;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rxs_lane_fmt u_fmt (
            .smp  (lane_smp[l]),
            .code (dec.code),
            .fmt  (fmt_e'(fmt_full)),
            .flag (flag),
            .aux  (aux),
            .word (lane_word[l])
        );
    end

    always_comb begin
        nxt.i = lane_word[0];
        nxt.q = lane_word[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) held_q <= nxt;
        end
    end

    assign out_i = held_q.i;
    assign out_q = held_q.q;
endmodule

// File: rtl/rx_iface_slicer_chk.sv
module rx_iface_slicer_chk
    import rxs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [SMP_W-1:0]  in_i,
    input logic [SMP_W-1:0]  in_q,
    input logic              narrowband,
    input logic              ext_ctrl,
    input logic [GAIN_W-1:0] ext_code,
    input logic              fmt_full,
    input logic [1:0]        aux_sel,
    input logic              agc_changed,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_i,
    input logic [WORD_W-1:0] out_q,
    input logic [GAIN_W-1:0] cur_gain
);
    a_r2_wideband_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !narrowband) |=> (cur_gain == '0));

    a_r3_external_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrowband && ext_ctrl) |=> (cur_gain == $past(ext_code)));

    a_r6_gain_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cur_gain));

    a_r11_words_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r7_symmetric_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fmt_full) |=>
        (out_i[WORD_W-1:OUT_W] == {(WORD_W - OUT_W){out_i[OUT_W-1]}} &&
         out_i[OUT_W-1:0] != {1'b1, {(OUT_W - 1){1'b0}}} &&
         out_q[OUT_W-1:0] != {1'b1, {(OUT_W - 1){1'b0}}}));

    a_r8_raw_sample: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_full) |=>
        (out_i[WORD_W-1:WORD_W-SMP_W] == $past(in_i) &&
         out_q[WORD_W-1:WORD_W-SMP_W] == $past(in_q)));

    a_r9_change_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_full && !agc_changed) |=>
        (out_i[AUX_W] == (cur_gain != $past(cur_gain)) && out_q[AUX_W] == out_i[AUX_W]));

    a_r10_aux_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_full && aux_sel == 2'd1) |=>
        (out_i[AUX_W-1:0] == AUX_W'(cur_gain)));
endmodule

bind rx_iface_slicer rx_iface_slicer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_i        (in_i),
    .in_q        (in_q),
    .narrowband  (narrowband),
    .ext_ctrl    (ext_ctrl),
    .ext_code    (ext_code),
    .fmt_full    (fmt_full),
    .aux_sel     (aux_sel),
    .agc_changed (agc_changed),
    .out_valid   (out_valid),
    .out_i       (out_i),
    .out_q       (out_q),
    .cur_gain    (cur_gain)
);

// File: tb/rx_iface_slicer_tb.sv
module rx_iface_slicer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [21:0] in_i = '0;
    logic [21:0] in_q = '0;
    logic [7:0]  power = '0;
    logic        narrowband = 1'b0;
    logic        ext_ctrl = 1'b0;
    logic [1:0]  ext_code = '0;
    logic        fmt_full = 1'b0;
    logic [1:0]  aux_sel = '0;
    logic [8:0]  ext_index = '0;
    logic        agc_changed = 1'b0;
    logic        out_valid;
    logic [31:0] out_i;
    logic [31:0] out_q;
    logic [1:0]  cur_gain;

    int errors = 0;
    int checks = 0;
    int m_gain = 0;
    logic        m_valid = 1'b0;
    logic [31:0] m_i = '0;
    logic [31:0] m_q = '0;

    always #10 clk = ~clk;

    rx_iface_slicer u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
        .power (power), .narrowband (narrowband), .ext_ctrl (ext_ctrl),
        .ext_code (ext_code), .fmt_full (fmt_full), .aux_sel (aux_sel),
        .ext_index (ext_index), .agc_changed (agc_changed),
        .out_valid (out_valid), .out_i (out_i), .out_q (out_q), .cur_gain (cur_gain)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pick_gain(int pwr, bit nb, bit ext, int extc, int cur);
        int hr, down, up;
        if (!nb) return 0;
        if (ext) return extc;
        hr = (pwr >= 200) ? 0 : 200 - pwr;
        down = hr / 12;
        if (down > 3) down = 3;
        up = (hr >= 1) ? (hr - 1) / 12 : 0;
        if (up > 3) up = 3;
        if (down < cur) return down;
        if (up > cur) return up;
        return cur;
    endfunction

    function automatic logic [31:0] round16(int x, int g);
        int v, mag, r;
        v = x * (1 << g);
        mag = (v < 0) ? -v : v;
        r = (mag + 32) / 64;
        if (r > 32767) r = 32767;
        if (v < 0) r = -r;
        return 32'(r);
    endfunction

    task automatic step(string req, bit v, int xi, int xq, int pwr, bit nb, bit ext,
                        int extc, bit fmt, int asel, int idx, bit agc);
        int g, aux;
        bit flag;
        in_valid = v; in_i = 22'(xi); in_q = 22'(xq); power = 8'(pwr);
        narrowband = nb; ext_ctrl = ext; ext_code = 2'(extc); fmt_full = fmt;
        aux_sel = 2'(asel); ext_index = 9'(idx); agc_changed = agc;
        if (v) begin
            g = pick_gain(pwr, nb, ext, extc, m_gain);
            flag = (g != m_gain) || agc;
            aux = (asel == 1) ? g : (asel == 2) ? idx : 0;
            if (fmt) begin
                m_i = {22'(xi), flag, 9'(aux)};
                m_q = {22'(xq), flag, 9'(aux)};
            end else begin
                m_i = round16(int'($signed(22'(xi))), g);
                m_q = round16(int'($signed(22'(xq))), g);
            end
            m_gain = g;
        end
        m_valid = v;
        @(negedge clk);
        check(req, "out_valid", 32'(out_valid), 32'(m_valid));
        check(req, "out_i", out_i, m_i);
        check(req, "out_q", out_q, m_q);
        check(req, "cur_gain", 32'(cur_gain), 32'(m_gain));
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11", "reset out_valid", 32'(out_valid), 32'd0);
        check("R11", "reset out_i", out_i, 32'd0);
        check("R11", "reset out_q", out_q, 32'd0);
        check("R11", "reset cur_gain", 32'(cur_gain), 32'd0);

        // R2: wideband forces 0 dB even with host code 3
        step("R2", 1, 1000, -1000, 100, 0, 1, 3, 0, 0, 0, 0);
        // R1 R3: host codes in narrowband
        for (int c = 0; c < 4; c++) step("R3", 1, 5000, -7000, 100, 1, 1, c, 0, 0, 0, 0);
        step("R1", 1, 4000, -4001, 100, 1, 1, 2, 0, 0, 0, 0);
        step("R2", 1, 4000, -4001, 100, 0, 1, 2, 0, 0, 0, 0);
        // R7: rounding half away from zero and symmetric clipping
        step("R7", 1, 32, -32, 100, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 31, -31, 100, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 96, -95, 100, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 2097151, -2097152, 100, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 1, 2097151, -2097152, 100, 1, 1, 3, 0, 0, 0, 0);
        step("R7", 1, 300000, -262144, 100, 1, 1, 3, 0, 0, 0, 0);
        // R4: internal thresholds
        step("R4", 1, 1234, 5678, 160, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 1234, 5678, 170, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 1234, 5678, 200, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 1, 1234, 5678, 250, 1, 0, 0, 0, 0, 0, 0);
        // R5: hysteresis around the first step
        step("R5", 1, 777, 888, 188, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 777, 888, 187, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 777, 888, 188, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 777, 888, 189, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 777, 888, 176, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 777, 888, 175, 1, 0, 0, 0, 0, 0, 0);
        // R6: no sample, no change of gain or words
        step("R6", 0, 9999, 1, 120, 1, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 9999, 1, 220, 1, 1, 3, 1, 2, 5, 1);
        step("R11", 1, -4444, 4444, 220, 1, 0, 0, 0, 0, 0, 0);
        // R8 R9 R10: full format
        step("R8", 1, 2097151, -2097152, 160, 1, 0, 0, 1, 0, 0, 0);
        step("R9", 1, 12345, -12345, 160, 1, 0, 0, 1, 1, 0, 0);
        step("R9", 1, 12345, -12345, 160, 1, 0, 0, 1, 1, 0, 1);
        step("R9", 1, 12345, -12345, 200, 1, 0, 0, 1, 1, 0, 0);
        step("R10", 1, -1, 1, 200, 1, 1, 2, 1, 1, 0, 0);
        step("R10", 1, -1, 1, 200, 1, 1, 2, 1, 2, 9'h1a5, 0);
        step("R10", 1, -1, 1, 200, 1, 1, 2, 1, 3, 9'h1a5, 0);
        step("R10", 1, -1, 1, 200, 1, 1, 2, 1, 0, 9'h1a5, 0);
        // R6: mixed random traffic compared every clock
        for (int n = 0; n < 3000; n++) begin
            step("R6", bit'($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 4194303)) - 2097152,
                 int'($urandom_range(0, 4194303)) - 2097152,
                 int'($urandom_range(150, 215)), bit'($urandom_range(0, 7) != 0),
                 bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 511)), bit'($urandom_range(0, 7) == 0));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule